// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a CPU register bus and fronts a one-time-programmable word array. Software writes an operation code, a word address and a data word into holding registers, then sets a go bit. An internal sequencer copies those three values at launch, stays busy for a fixed number of cycles that depends on the operation, applies the operation, and then raises a done flag. The flag stays up until software writes the go bit back to zero. After that write the block is idle again and accepts the next launch.

A read fetches one 64-bit row, which is two neighbouring 32-bit words, into two read-only row registers. A burn operation can only set bits in a stored word. It is refused unless an unlock sequence has been completed first. The unlock sequence is four key values, each delivered through the unlock operation. One more operation, aimed at a fixed address with a fixed data pattern, switches the error-correction mode flag off or on. The array is a plain register model. It has no analog fuse timing and no real error-correction coding.

Bus map (byte offsets): mode 0x00, operation 0x04, go 0x08, status 0x0C, address 0x28, write data 0x2C, row low word 0x30, row high word 0x34. Reading an unmapped offset returns zero. Status bit positions are: bit 0 busy, bit 1 done, bit 2 burn accepted, bit 3 error-correction mode on, bit 4 burning unlocked. Operation codes are: read 0x00, unlock step 0x02, relock 0x03, burn 0x08, error-correction control 0x10. Any other code completes as a no-op.

Top module: `fuse_bank_ctrl`

## Requirements
- R1: After reset, mode, operation, go, address, write data and both row registers read 0, and status reads 0x08 (error-correction on, everything else clear).
- R2: Only bit 0 of mode, the low 6 bits of the operation register and the low 16 bits of the address register are kept; higher written bits read back as zero. The write-data register keeps all 32 bits. Writes to the row registers, the status register or unmapped offsets change nothing.
- R3: A write of 1 to go while mode bit 0 is clear is ignored: go reads 0, and the status never shows busy or done.
- R4: After the bus write that launches an operation, status bit 0 is set, and status bit 1 rises on exactly the 4th following clock edge for read, the 16th for burn and the 2nd for every other code. Busy and done are never set together.
- R5: Done stays set until go is written 0. That write clears done and burn-accepted at the same edge. Writes to go while busy, and writes of 1 while done, are ignored.
- R6: A read uses only the low 11 bits of the address. Row low returns the word at that index with bit 0 cleared, and row high returns the word at that index with bit 0 set.
- R7: Unlock operations that carry write-data values 0xF, 0x4, 0x8 and 0xD, in that order, set status bit 4.
- R8: An unlock operation whose data is not the next expected key restarts the sequence and clears status bit 4. A relock operation also clears it.
- R9: A burn while unlocked ORs the write data into the addressed word, so no stored bit is ever cleared, and sets status bit 2 together with done.
- R10: A burn while locked sets done, leaves status bit 2 clear and leaves the array unchanged.
- R11: An error-correction control operation at address 0x1A with data 0x00EC0000 clears status bit 3. With data 0xFF13FFFF it sets status bit 3. Any other address or data leaves status bit 3 as it was.
- R12: An operation uses the operation, address and data values present at its launch. Bus writes to those registers while the operation is busy, including in the cycle it completes, do not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
Two things can fall on the same clock edge: a CPU write to the operation, address or data holding register, and the completion of a busy operation that depends on those values. The bench launches a row read. It rewrites the address register while the read is busy, then rewrites the operation register in exactly the cycle the read completes. It then judges that the row registers hold the data of the launch-time address, that the status shows a finished read rather than a burn, and that both holding registers have taken their new values.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int DATA_W = 32;
    localparam int BUS_AW = 8;
    localparam int OP_W   = 6;
    localparam int LOC_W  = 16;

    // bus byte offsets
    localparam logic [BUS_AW-1:0] OFS_MODE   = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_OP     = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_GO     = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_STAT   = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_LOC    = 8'h28;
    localparam logic [BUS_AW-1:0] OFS_WDAT   = 8'h2C;
    localparam logic [BUS_AW-1:0] OFS_ROW_LO = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_ROW_HI = 8'h34;

    // operation codes
    localparam logic [OP_W-1:0] OP_READ   = 6'h00;
    localparam logic [OP_W-1:0] OP_UNLOCK = 6'h02;
    localparam logic [OP_W-1:0] OP_LOCK   = 6'h03;
    localparam logic [OP_W-1:0] OP_BURN   = 6'h08;
    localparam logic [OP_W-1:0] OP_ECC    = 6'h10;

    // status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_OK   = 2;
    localparam int ST_ECC  = 3;
    localparam int ST_OPEN = 4;

    localparam logic [LOC_W-1:0]  ECC_LOC     = 16'h001A;
    localparam logic [DATA_W-1:0] ECC_OFF_VAL = 32'h00EC_0000;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BUSY = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [LOC_W-1:0]  loc;
        logic [DATA_W-1:0] data;
    } fuse_cmd_t;

    typedef struct packed {
        logic open;
        logic ecc_on;
        logic ok;
        logic done;
        logic busy;
    } fuse_flags_t;

    // key expected at each unlock step
    function automatic logic [DATA_W-1:0] unlock_key(input logic [1:0] step);
        case (step)
            2'd0:    return 32'h0000_000F;
            2'd1:    return 32'h0000_0004;
            2'd2:    return 32'h0000_0008;
            default: return 32'h0000_000D;
        endcase
    endfunction

    // busy cycles for an operation code
    function automatic int op_cycles(input logic [OP_W-1:0] op,
                                     input int rd_l, input int pg_l, input int misc_l);
        if (op == OP_READ)      return rd_l;
        else if (op == OP_BURN) return pg_l;
        else                    return misc_l;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input fuse_flags_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_BUSY] = f.busy;
        w[ST_DONE] = f.done;
        w[ST_OK]   = f.ok;
        w[ST_ECC]  = f.ecc_on;
        w[ST_OPEN] = f.open;
        return w;
    endfunction

endpackage

// File: rtl/fuse_array.sv
module fuse_array
    import fuse_pkg::*;
#(
    parameter int WORDS = 2048,
    localparam int IDX_W = $clog2(WORDS),
    localparam int ROW_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burn_en,
    input  logic [IDX_W-1:0]  burn_idx,
    input  logic [DATA_W-1:0] burn_bits,
    input  logic [ROW_W-1:0]  row_idx,
    output logic [DATA_W-1:0] row_lo,
    output logic [DATA_W-1:0] row_hi
);

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                cells[i] <= '0;
            end
        end else if (burn_en) begin
            // fuses can only be blown, never restored
            cells[burn_idx] <= cells[burn_idx] | burn_bits;
        end
    end

    assign row_lo = cells[{row_idx, 1'b0}];
    assign row_hi = cells[{row_idx, 1'b1}];

endmodule

// File: rtl/fuse_regfile.sv
module fuse_regfile
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              seq_idle,
    input  logic              seq_done,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] row_lo,
    input  logic [DATA_W-1:0] row_hi,
    output logic              mode_en,
    output logic              start_q,
    output logic              launch,
    output logic              release_o,
    output fuse_cmd_t         cmd
);

    logic              mode_q;
    logic [OP_W-1:0]   op_q;
    logic [LOC_W-1:0]  loc_q;
    logic [DATA_W-1:0] wdat_q;
    logic              go_wr;

    assign go_wr     = bus_wr && (bus_addr == OFS_GO);
    assign launch    = go_wr && bus_wdata[0] && mode_q && seq_idle && !start_q;
    assign release_o = go_wr && !bus_wdata[0] && seq_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            op_q    <= '0;
            loc_q   <= '0;
            wdat_q  <= '0;
            start_q <= 1'b0;
        end else begin
            if (launch)         start_q <= 1'b1;
            else if (release_o) start_q <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    OFS_MODE: mode_q <= bus_wdata[0];
                    OFS_OP:   op_q   <= bus_wdata[OP_W-1:0];
                    OFS_LOC:  loc_q  <= bus_wdata[LOC_W-1:0];
                    OFS_WDAT: wdat_q <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE:   bus_rdata[0]        = mode_q;
            OFS_OP:     bus_rdata[OP_W-1:0] = op_q;
            OFS_GO:     bus_rdata[0]        = start_q;
            OFS_STAT:   bus_rdata           = status_word;
            OFS_LOC:    bus_rdata[LOC_W-1:0] = loc_q;
            OFS_WDAT:   bus_rdata           = wdat_q;
            OFS_ROW_LO: bus_rdata           = row_lo;
            OFS_ROW_HI: bus_rdata           = row_hi;
            default:    bus_rdata           = '0;
        endcase
    end

    assign mode_en  = mode_q;
    assign cmd.op   = op_q;
    assign cmd.loc  = loc_q;
    assign cmd.data = wdat_q;

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int RD_LAT   = 4,
    parameter int PG_LAT   = 16,
    parameter int MISC_LAT = 2,
    parameter int IDX_W    = 11,
    localparam int ROW_W   = IDX_W - 1,
    localparam int MAX_LAT = (RD_LAT > PG_LAT) ? ((RD_LAT > MISC_LAT) ? RD_LAT : MISC_LAT)
                                               : ((PG_LAT > MISC_LAT) ? PG_LAT : MISC_LAT),
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              release_i,
    input  fuse_cmd_t         cmd_in,
    input  logic [DATA_W-1:0] arr_lo,
    input  logic [DATA_W-1:0] arr_hi,
    output logic              burn_en,
    output logic [IDX_W-1:0]  burn_idx,
    output logic [DATA_W-1:0] burn_bits,
    output logic [ROW_W-1:0]  row_idx,
    output logic [DATA_W-1:0] cap_lo,
    output logic [DATA_W-1:0] cap_hi,
    output fuse_flags_t       flags,
    output logic              idle,
    output logic              finish,
    output fuse_cmd_t         snap
);

    sq_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ok_q;
    logic             ecc_q;
    logic             open_q;
    logic [1:0]       step_q;
    logic             key_hit;

    assign finish    = (state_q == SQ_BUSY) && (cnt_q == '0);
    assign idle      = (state_q == SQ_IDLE);
    assign key_hit   = (snap.data == unlock_key(step_q));
    assign burn_idx  = snap.loc[IDX_W-1:0];
    assign burn_bits = snap.data;
    assign burn_en   = finish && (snap.op == OP_BURN) && open_q;
    assign row_idx   = snap.loc[IDX_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            snap    <= '0;
            ok_q    <= 1'b0;
            ecc_q   <= 1'b1;
            open_q  <= 1'b0;
            step_q  <= 2'd0;
            cap_lo  <= '0;
            cap_hi  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        snap    <= cmd_in;
                        cnt_q   <= CNT_W'(op_cycles(cmd_in.op, RD_LAT, PG_LAT, MISC_LAT) - 1);
                        ok_q    <= 1'b0;
                        state_q <= SQ_BUSY;
                    end
                end
                SQ_BUSY: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_DONE;
                        case (snap.op)
                            OP_READ: begin
                                cap_lo <= arr_lo;
                                cap_hi <= arr_hi;
                            end
                            OP_UNLOCK: begin
                                if (!key_hit) begin
                                    step_q <= 2'd0;
                                    open_q <= 1'b0;
                                end else if (step_q == 2'd3) begin
                                    step_q <= 2'd0;
                                    open_q <= 1'b1;
                                end else begin
                                    step_q <= step_q + 2'd1;
                                end
                            end
                            OP_LOCK: begin
                                step_q <= 2'd0;
                                open_q <= 1'b0;
                            end
                            OP_BURN: ok_q <= open_q;
                            OP_ECC: begin
                                if (snap.loc == ECC_LOC) begin
                                    if (snap.data == ECC_OFF_VAL)       ecc_q <= 1'b0;
                                    else if (snap.data == ~ECC_OFF_VAL) ecc_q <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_DONE: begin
                    if (release_i) begin
                        state_q <= SQ_IDLE;
                        ok_q    <= 1'b0;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign flags.busy   = (state_q == SQ_BUSY);
    assign flags.done   = (state_q == SQ_DONE);
    assign flags.ok     = ok_q;
    assign flags.ecc_on = ecc_q;
    assign flags.open   = open_q;

endmodule

// File: rtl/fuse_bank_ctrl.sv
module fuse_bank_ctrl
    import fuse_pkg::*;
#(
    parameter int WORDS    = 2048,
    parameter int RD_LAT   = 4,
    parameter int PG_LAT   = 16,
    parameter int MISC_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata
);

    localparam int IDX_W = $clog2(WORDS);
    localparam int ROW_W = IDX_W - 1;

    logic              mode_en;
    logic              start_q;
    logic              launch;
    logic              release_p;
    logic              seq_idle;
    logic              finish;
    fuse_cmd_t         cmd;
    fuse_cmd_t         snap;
    fuse_flags_t       flags;
    logic [DATA_W-1:0] status_word;
    logic              burn_en;
    logic [IDX_W-1:0]  burn_idx;
    logic [DATA_W-1:0] burn_bits;
    logic [ROW_W-1:0]  row_idx;
    logic [DATA_W-1:0] arr_lo, arr_hi;
    logic [DATA_W-1:0] cap_lo, cap_hi;
    logic              busy, done, prog_ok, open;
    logic [OP_W-1:0]   snap_op;
    logic [LOC_W-1:0]  snap_loc;

    assign status_word = pack_status(flags);
    assign busy        = flags.busy;
    assign done        = flags.done;
    assign prog_ok     = flags.ok;
    assign open        = flags.open;
    assign snap_op     = snap.op;
    assign snap_loc    = snap.loc;

    fuse_regfile regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .seq_idle    (seq_idle),
        .seq_done    (flags.done),
        .status_word (status_word),
        .row_lo      (cap_lo),
        .row_hi      (cap_hi),
        .mode_en     (mode_en),
        .start_q     (start_q),
        .launch      (launch),
        .release_o   (release_p),
        .cmd         (cmd)
    );

    fuse_seq #(
        .RD_LAT   (RD_LAT),
        .PG_LAT   (PG_LAT),
        .MISC_LAT (MISC_LAT),
        .IDX_W    (IDX_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .release_i (release_p),
        .cmd_in    (cmd),
        .arr_lo    (arr_lo),
        .arr_hi    (arr_hi),
        .burn_en   (burn_en),
        .burn_idx  (burn_idx),
        .burn_bits (burn_bits),
        .row_idx   (row_idx),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .flags     (flags),
        .idle      (seq_idle),
        .finish    (finish),
        .snap      (snap)
    );

    fuse_array #(
        .WORDS (WORDS)
    ) arr_i (
        .clk       (clk),
        .rst       (rst),
        .burn_en   (burn_en),
        .burn_idx  (burn_idx),
        .burn_bits (burn_bits),
        .row_idx   (row_idx),
        .row_lo    (arr_lo),
        .row_hi    (arr_hi)
    );

endmodule

// File: rtl/fuse_bank_ctrl_chk.sv
module fuse_bank_ctrl_chk
    import fuse_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_en,
    input logic             start_q,
    input logic             busy,
    input logic             done,
    input logic             prog_ok,
    input logic             open,
    input logic             finish,
    input logic [OP_W-1:0]  snap_op,
    input logic [LOC_W-1:0] snap_loc
);

    assert_done_holds_go_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> start_q);

    assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(start_q) |-> (!done && !prog_ok));

    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_ok_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        prog_ok |-> done);

    assert_mode_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_en && !start_q) |=> !start_q);

    assert_snapshot_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(snap_op) && $stable(snap_loc)));

    assert_unlock_on_finish_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(open) |-> $past(finish));

endmodule

bind fuse_bank_ctrl fuse_bank_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .mode_en  (mode_en),
    .start_q  (start_q),
    .busy     (busy),
    .done     (done),
    .prog_ok  (prog_ok),
    .open     (open),
    .finish   (finish),
    .snap_op  (snap_op),
    .snap_loc (snap_loc)
);

// File: tb/fuse_bank_ctrl_tb.sv
module fuse_bank_ctrl_tb_top;
    import fuse_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  ofs;
        logic [31:0] wv;
        logic [31:0] ev;
    } vec_t;

    // R2: write then read back, with masking and read-only targets
    localparam vec_t VECS [7] = '{
        '{ofs: 8'h00, wv: 32'hFFFF_FFFF, ev: 32'h0000_0001},
        '{ofs: 8'h04, wv: 32'hFFFF_FFC8, ev: 32'h0000_0008},
        '{ofs: 8'h28, wv: 32'hABCD_1234, ev: 32'h0000_1234},
        '{ofs: 8'h2C, wv: 32'hDEAD_BEEF, ev: 32'hDEAD_BEEF},
        '{ofs: 8'h04, wv: 32'h0000_0050, ev: 32'h0000_0010},
        '{ofs: 8'h30, wv: 32'h0000_1234, ev: 32'h0000_0000},
        '{ofs: 8'h40, wv: 32'h5555_AAAA, ev: 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_vec = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_bank_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_cmd(input logic [31:0] op, input logic [31:0] loc,
                           input logic [31:0] data, output logic [31:0] st);
        logic [31:0] s;
        wr(OFS_OP, op);
        wr(OFS_LOC, loc);
        wr(OFS_WDAT, data);
        wr(OFS_GO, 32'h1);
        s = '0;
        for (int i = 0; i < 40; i++) begin
            rd(OFS_STAT, s);
            if (s[ST_DONE]) break;
            @(negedge clk);
        end
        st = s;
        wr(OFS_GO, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] st;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(OFS_STAT, v);   check("R1", "status", v, 32'h08);
        rd(OFS_MODE, v);   check("R1", "mode", v, 32'h0);
        rd(OFS_GO, v);     check("R1", "go", v, 32'h0);
        rd(OFS_ROW_LO, v); check("R1", "row lo", v, 32'h0);
        rd(OFS_ROW_HI, v); check("R1", "row hi", v, 32'h0);

        // R3 go ignored with mode clear
        wr(OFS_GO, 32'h1);
        rd(OFS_GO, v); check("R3", "go readback", v, 32'h0);
        repeat (20) @(negedge clk);
        rd(OFS_STAT, v); check("R3", "status idle", v, 32'h08);

        // R2 table walk
        foreach (VECS[i]) begin
            wr(VECS[i].ofs, VECS[i].wv);
            rd(VECS[i].ofs, v);
            check("R2", $sformatf("readback ofs %h", VECS[i].ofs), v, VECS[i].ev);
        end

        // R4 read latency, R5 hold and ignore
        wr(OFS_MODE, 32'h1);
        wr(OFS_OP, OP_READ);
        wr(OFS_LOC, 32'h5);
        wr(OFS_GO, 32'h1);
        repeat (4) @(negedge clk);
        rd(OFS_STAT, v); check("R4", "read busy after 3 edges", v, 32'h09);
        @(negedge clk);
        rd(OFS_STAT, v); check("R4", "read done after 4 edges", v, 32'h0A);
        repeat (5) @(negedge clk);
        rd(OFS_STAT, v); check("R5", "done held", v, 32'h0A);
        wr(OFS_GO, 32'h1);
        rd(OFS_STAT, v); check("R5", "go 1 while done ignored", v, 32'h0A);
        wr(OFS_GO, 32'h0);
        rd(OFS_STAT, v); check("R5", "done cleared", v, 32'h08);

        // R10 locked burn
        run_cmd(OP_BURN, 32'h3, 32'hFF, st);
        check("R10", "locked burn status", st, 32'h0A);
        run_cmd(OP_READ, 32'h3, 32'h0, st);
        rd(OFS_ROW_HI, v); check("R10", "word 3 untouched", v, 32'h0);

        // R7 unlock sequence
        run_cmd(OP_UNLOCK, 32'h0, 32'hF, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h4, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h8, st);
        check("R7", "not open after 3 keys", st, 32'h0A);
        run_cmd(OP_UNLOCK, 32'h0, 32'hD, st);
        check("R7", "open after 4 keys", st, 32'h1A);

        // R4 burn latency, R9 burn, R5 go 0 while busy ignored
        wr(OFS_OP, OP_BURN);
        wr(OFS_LOC, 32'h3);
        wr(OFS_WDAT, 32'hF0);
        wr(OFS_GO, 32'h1);
        wr(OFS_GO, 32'h0);
        rd(OFS_GO, v); check("R5", "go 0 while busy ignored", v, 32'h1);
        repeat (15) @(negedge clk);
        rd(OFS_STAT, v); check("R4", "burn busy after 15 edges", v, 32'h19);
        @(negedge clk);
        rd(OFS_STAT, v); check("R9", "burn done ok after 16 edges", v, 32'h1E);
        wr(OFS_GO, 32'h0);
        rd(OFS_STAT, v); check("R5", "ok cleared by release", v, 32'h18);
        run_cmd(OP_BURN, 32'h3, 32'h01, st);
        check("R9", "second burn status", st, 32'h1E);
        run_cmd(OP_BURN, 32'h3, 32'h00, st);
        run_cmd(OP_BURN, 32'h2, 32'hA5, st);

        // R6 row read and address aliasing
        run_cmd(OP_READ, 32'h0803, 32'h0, st);
        rd(OFS_ROW_LO, v); check("R6", "row lo via alias", v, 32'hA5);
        rd(OFS_ROW_HI, v); check("R9", "word 3 ORed", v, 32'hF1);
        run_cmd(OP_READ, 32'h0, 32'h0, st);
        run_cmd(OP_READ, 32'h2, 32'h0, st);
        rd(OFS_ROW_LO, v); check("R6", "row lo even addr", v, 32'hA5);

        // R12 writes during busy and in completion cycle
        run_cmd(OP_READ, 32'h0, 32'h0, st);
        wr(OFS_LOC, 32'h2);
        wr(OFS_GO, 32'h1);
        wr(OFS_LOC, 32'h40);
        repeat (3) @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFS_OP; bus_wdata = OP_BURN;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd(OFS_STAT, v);   check("R12", "read finished, no burn ok", v, 32'h1A);
        rd(OFS_ROW_LO, v); check("R12", "launch address used", v, 32'hA5);
        wr(OFS_GO, 32'h0);
        rd(OFS_OP, v);  check("R12", "op register updated", v, 32'h08);
        rd(OFS_LOC, v); check("R12", "loc register updated", v, 32'h40);

        // R8 relock and wrong sequences
        run_cmd(OP_LOCK, 32'h0, 32'h0, st);
        check("R8", "relock", st, 32'h0A);
        run_cmd(OP_UNLOCK, 32'h0, 32'hF, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h4, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h7, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h8, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'hD, st);
        check("R8", "wrong key restarts", st, 32'h0A);
        run_cmd(OP_UNLOCK, 32'h0, 32'hF, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h4, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'h8, st);
        run_cmd(OP_UNLOCK, 32'h0, 32'hD, st);
        check("R7", "reopened", st, 32'h1A);
        run_cmd(OP_UNLOCK, 32'h0, 32'h5, st);
        check("R8", "bad key closes", st, 32'h0A);
        run_cmd(OP_BURN, 32'h7, 32'hFFFF_FFFF, st);
        check("R10", "burn after relock refused", st, 32'h0A);
        run_cmd(OP_READ, 32'h6, 32'h0, st);
        rd(OFS_ROW_HI, v); check("R10", "word 7 untouched", v, 32'h0);

        // R11 error-correction control
        run_cmd(OP_ECC, 32'h1A, 32'h00EC_0000, st);
        check("R11", "ecc off", st, 32'h02);
        run_cmd(OP_ECC, 32'h1B, 32'hFF13_FFFF, st);
        check("R11", "wrong address no change", st, 32'h02);
        run_cmd(OP_ECC, 32'h1A, 32'h1234_5678, st);
        check("R11", "wrong data no change", st, 32'h02);
        run_cmd(OP_ECC, 32'h1A, 32'hFF13_FFFF, st);
        check("R11", "ecc on", st, 32'h0A);

        // R3 again after clearing mode
        wr(OFS_MODE, 32'h0);
        wr(OFS_GO, 32'h1);
        rd(OFS_GO, v); check("R3", "go ignored, mode cleared", v, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule